// File: doc/BRIEF.md
# Word-wide DMA end-of-transfer sequencer

This block runs a DMA transfer, one 16-bit word at a time, between an endpoint buffer and system memory, and decides when the transfer is over. When the enable bit rises, a working byte counter is loaded from the programmed count and an address pointer is loaded from the programmed base address. For each word the block asks for the bus, waits for the grant, moves the word, then gives the bus back. It waits for the grant to be withdrawn before it asks again.

The transfer ends in one of three ways, and each is enabled separately. The first is the working count running out. The second applies only on a receive endpoint: a word marked as the end of a short packet, which ends the transfer once that word has been moved. The third is software dropping the enable bit. The first two set a sticky done flag and raise a one-cycle interrupt. The third stops all activity quietly.

Top module: `dma_eot_ctrl`

## Requirements
- R1: A 0-to-1 change of `cfg_enable` loads `bytes_left` from `cfg_byte_count` and `mem_addr` from `cfg_base_addr` on the next clock edge, and clears `xfer_done` on that same edge.
- R2: Each moved word produces exactly one cycle of `word_strobe`. After the word, `mem_addr` is higher by 2 and `bytes_left` is lower by 2.
- R3: With `cfg_cnt_stop`=1, the word that brings `bytes_left` to zero ends the transfer. The end raises `xfer_done` and an interrupt, and no further words are moved.
- R4: With `cfg_short_stop`=1 and `cfg_rx_dir`=1 (receive endpoint), a word presented while `ep_short_end`=1 is moved, and then the transfer ends with an interrupt.
- R5: Driving `cfg_enable` to 0 drops `bus_req` in the same cycle. After that no further `word_strobe` occurs, no interrupt is raised, and `xfer_done` stays 0.
- R6: With `cfg_rx_dir`=0 (transmit endpoint), `ep_short_end` has no effect. The count end still stops the transfer while `ep_word_ready` remains 1.
- R7: `bus_req` stays high until the grant arrives and drops after each word. It does not rise again while `bus_grant` is still high.
- R8: `xfer_irq` is high for exactly one cycle, three cycles after the `word_strobe` of the last word when the grant is withdrawn one cycle after the request drops. `xfer_done` then stays high, even after `cfg_enable` is cleared, until `cfg_enable` rises again.
- R9: The working count never wraps. A word moved when fewer than 2 bytes remain leaves `bytes_left` at 0.
- R10: When the count end and the short-packet end occur on the same word, exactly one interrupt is raised.
- R11: With `cfg_cnt_stop`=0, reaching zero does not end the transfer. Words keep moving and `bytes_left` stays 0.
- R12: During and after reset, `bus_req`, `word_strobe`, `xfer_done` and `xfer_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | DMA enable; rising edge starts a transfer |
| cfg_cnt_stop | input | 1 | End the transfer when the count runs out |
| cfg_short_stop | input | 1 | End the transfer on a short packet |
| cfg_rx_dir | input | 1 | 1 = receive endpoint, 0 = transmit endpoint |
| cfg_byte_count | input | CNT_W | Programmed byte count |
| cfg_base_addr | input | ADDR_W | Start address in memory |
| ep_word_ready | input | 1 | The endpoint buffer can move a word |
| ep_short_end | input | 1 | The current word ends a short packet |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| word_strobe | output | 1 | One word moves in this cycle |
| mem_addr | output | ADDR_W | Current memory address |
| bytes_left | output | CNT_W | Working byte count |
| xfer_done | output | 1 | Sticky end-of-transfer flag |
| xfer_irq | output | 1 | One-cycle end-of-transfer interrupt |

## Verification
A corrupted working count shows at once on `bytes_left`. It also shows as the wrong number of `word_strobe` pulses before the interrupt, and the 64-byte run exposes an off-by-one within 32 words. A stuck or skipped handshake state shows within a few cycles as `bus_req` rising while the grant is still high, or as a word with no request. A lost end-pending flag shows as words that keep moving after the short word, or as a missing interrupt three cycles after the last strobe.

// File: rtl/dma_eot_pkg.sv
package dma_eot_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ARM  = 3'd1,
      ST_REQ  = 3'd2,
      ST_REL  = 3'd3,
      ST_END  = 3'd4
   } eot_state_t;
endpackage

// File: rtl/dma_eot_count.sv
module dma_eot_count #(
   parameter int CNT_W = 16,
   parameter int STEP  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             last_word
);
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (step) count <= (count > STEP_V) ? (count - STEP_V) : '0;
   end

   assign last_word = (count <= STEP_V);

   // Count must never grow on a step (no wrap below zero)
   p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(step) && !$past(load)) |-> (count <= $past(count)))
      else $error("count wrapped");
endmodule

// File: rtl/dma_eot_addr.sv
module dma_eot_addr #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (step) addr <= addr + STEP_V;
   end

   // Address only moves on a load or a word step
   p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(step) && !$past(load)) |-> $stable(addr))
      else $error("address moved without a word");
endmodule

// File: rtl/dma_eot_sync.sv
module dma_eot_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_flops
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], din};
         end
         assign dout = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dma_eot_fsm.sv
module dma_eot_fsm
   import dma_eot_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic cnt_stop,
   input  logic short_stop,
   input  logic rx_dir,
   input  logic word_ready,
   input  logic short_end,
   input  logic last_word,
   input  logic grant,
   output logic load,
   output logic step,
   output logic bus_req,
   output logic done,
   output logic irq
);
   eot_state_t st, nxt;
   logic en_q, end_pend, set_end, hit;

   assign hit = (cnt_stop & last_word) | (short_stop & rx_dir & short_end);

   always_comb begin
      nxt     = st;
      load    = 1'b0;
      step    = 1'b0;
      set_end = 1'b0;
      if (!enable) begin
         nxt = ST_IDLE;
      end else begin
         case (st)
            ST_IDLE: if (!en_q) begin nxt = ST_ARM; load = 1'b1; end
            ST_ARM:  if (word_ready) nxt = ST_REQ;
            ST_REQ:  if (grant) begin step = 1'b1; nxt = ST_REL; end
            ST_REL:  if (!grant) begin
                        if (end_pend) begin nxt = ST_END; set_end = 1'b1; end
                        else nxt = ST_ARM;
                     end
            ST_END:  nxt = ST_END;
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         en_q     <= 1'b0;
         end_pend <= 1'b0;
         done     <= 1'b0;
         irq      <= 1'b0;
      end else begin
         st   <= nxt;
         en_q <= enable;
         irq  <= set_end;
         if (load)      end_pend <= 1'b0;
         else if (step) end_pend <= hit;
         if (load)         done <= 1'b0;
         else if (set_end) done <= 1'b1;
      end
   end

   assign bus_req = enable && (st == ST_REQ);

   p_req_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !grant) else $error("request while granted");
   p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq) else $error("interrupt longer than one cycle");
   p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !irq) else $error("interrupt after disable");
   p_done_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(load)) else $error("done cleared without restart");
   p_irq_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done) else $error("interrupt without done");
endmodule

// File: rtl/dma_eot_ctrl.sv
module dma_eot_ctrl #(
   parameter int CNT_W        = 16,
   parameter int ADDR_W       = 32,
   parameter int WORD_BYTES   = 2,
   parameter int GRANT_SYNC   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_cnt_stop,
   input  logic              cfg_short_stop,
   input  logic              cfg_rx_dir,
   input  logic [CNT_W-1:0]  cfg_byte_count,
   input  logic [ADDR_W-1:0] cfg_base_addr,
   input  logic              ep_word_ready,
   input  logic              ep_short_end,
   output logic              bus_req,
   input  logic              bus_grant,
   output logic              word_strobe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [CNT_W-1:0]  bytes_left,
   output logic              xfer_done,
   output logic              xfer_irq
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small");
      end
      if (WORD_BYTES < 1 || WORD_BYTES >= (1 << (CNT_W - 1))) begin : g_bad_word
         $error("WORD_BYTES out of range");
      end
      if (GRANT_SYNC < 0 || GRANT_SYNC > 3) begin : g_bad_sync
         $error("GRANT_SYNC out of range");
      end
   endgenerate

   logic grant_s, load, step, last_word;

   dma_eot_sync #(.STAGES(GRANT_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(bus_grant), .dout(grant_s));

   dma_eot_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .enable(cfg_enable),
      .cnt_stop(cfg_cnt_stop), .short_stop(cfg_short_stop), .rx_dir(cfg_rx_dir),
      .word_ready(ep_word_ready), .short_end(ep_short_end), .last_word(last_word),
      .grant(grant_s), .load(load), .step(step), .bus_req(bus_req),
      .done(xfer_done), .irq(xfer_irq));

   dma_eot_count #(.CNT_W(CNT_W), .STEP(WORD_BYTES)) u_count (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_byte_count),
      .step(step), .count(bytes_left), .last_word(last_word));

   dma_eot_addr #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_base_addr),
      .step(step), .addr(mem_addr));

   assign word_strobe = step;
endmodule

// File: tb/dma_eot_ctrl_tb.sv
module dma_eot_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0, cfg_cnt_stop = 1'b0, cfg_short_stop = 1'b0, cfg_rx_dir = 1'b0;
   logic [15:0] cfg_byte_count = '0;
   logic [31:0] cfg_base_addr = '0;
   logic        ep_word_ready = 1'b0, ep_short_end = 1'b0;
   logic        bus_req, word_strobe, xfer_done, xfer_irq;
   logic        bus_grant = 1'b0;
   logic [31:0] mem_addr;
   logic [15:0] bytes_left;

   int tests = 0, fails = 0;
   int cyc = 0, n_xfer = 0, n_irq = 0, last_x = 0, irq_at = 0, viol = 0;
   int grant_hold = 0, hold_left = 0;
   logic prev_req = 1'b0;

   always #2.5 clk = ~clk;

   dma_eot_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cnt_stop(cfg_cnt_stop),
      .cfg_short_stop(cfg_short_stop), .cfg_rx_dir(cfg_rx_dir),
      .cfg_byte_count(cfg_byte_count), .cfg_base_addr(cfg_base_addr),
      .ep_word_ready(ep_word_ready), .ep_short_end(ep_short_end),
      .bus_req(bus_req), .bus_grant(bus_grant), .word_strobe(word_strobe),
      .mem_addr(mem_addr), .bytes_left(bytes_left),
      .xfer_done(xfer_done), .xfer_irq(xfer_irq));

   // Bus arbiter model: grant one cycle after request, optionally held longer
   always @(posedge clk) begin
      if (bus_req) begin
         bus_grant <= 1'b1; hold_left <= grant_hold;
      end else if (bus_grant && hold_left != 0) begin
         hold_left <= hold_left - 1;
      end else begin
         bus_grant <= 1'b0;
      end
   end

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (word_strobe) begin n_xfer = n_xfer + 1; last_x = cyc; end
      if (xfer_irq) begin n_irq = n_irq + 1; irq_at = cyc; end
      if (rst_n && bus_req && !prev_req && bus_grant) viol = viol + 1;
      prev_req = bus_req;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic start(input logic [15:0] cnt, input logic [31:0] base,
                        input logic cs, input logic ss, input logic rx);
      @(negedge clk);
      cfg_enable = 1'b0;
      cfg_byte_count = cnt; cfg_base_addr = base;
      cfg_cnt_stop = cs; cfg_short_stop = ss; cfg_rx_dir = rx;
      ep_short_end = 1'b0; ep_word_ready = 1'b1;
      @(negedge clk);
      cfg_enable = 1'b1;
   endtask

   task automatic wait_done(input int limit, input string tag);
      int k = 0;
      while (!xfer_done && k < limit) begin @(negedge clk); k++; end
      chk(xfer_done === 1'b1, tag, xfer_done, 1);
   endtask

   task automatic stop();
      @(negedge clk);
      cfg_enable = 1'b0; ep_short_end = 1'b0;
      cycles(3);
   endtask

   task automatic t_reset();
      chk(bus_req === 1'b0, "R12 bus_req", bus_req, 0);
      chk(word_strobe === 1'b0, "R12 word_strobe", word_strobe, 0);
      chk(xfer_done === 1'b0 && xfer_irq === 1'b0, "R12 done/irq", {xfer_done, xfer_irq}, 0);
   endtask

   task automatic t_full64();
      int x0, i0;
      x0 = n_xfer; i0 = n_irq;
      start(16'd64, 32'h1000, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk(bytes_left == 16'd64, "R1 count loaded", bytes_left, 64);
      chk(mem_addr == 32'h1000, "R1 addr loaded", mem_addr, 32'h1000);
      wait_done(1000, "R3 done after 64 bytes");
      cycles(40);
      chk(n_xfer - x0 == 32, "R2 word count", n_xfer - x0, 32);
      chk(mem_addr == 32'h1040, "R2 final addr", mem_addr, 32'h1040);
      chk(bytes_left == 16'd0, "R3 final count", bytes_left, 0);
      chk(n_irq - i0 == 1, "R8 single irq", n_irq - i0, 1);
      chk(irq_at - last_x == 3, "R8 irq timing", irq_at - last_x, 3);
      chk(viol == 0, "R7 request while granted", viol, 0);
      // R6: transmit endpoint stops on count even with data still ready
      chk(ep_word_ready === 1'b1 && bus_req === 1'b0, "R6 stopped with data", bus_req, 0);
   endtask

   task automatic t_restart();
      @(negedge clk);
      cfg_enable = 1'b0;
      cycles(3);
      chk(xfer_done === 1'b1, "R8 done held while disabled", xfer_done, 1);
      cfg_byte_count = 16'd6; cfg_base_addr = 32'h2000;
      cfg_enable = 1'b1;
      @(negedge clk);
      chk(xfer_done === 1'b0, "R1 done cleared on restart", xfer_done, 0);
      chk(bytes_left == 16'd6, "R1 reload count", bytes_left, 6);
      chk(mem_addr == 32'h2000, "R1 reload addr", mem_addr, 32'h2000);
      wait_done(500, "R3 restart done");
      chk(mem_addr == 32'h2006, "R2 restart addr", mem_addr, 32'h2006);
      stop();
   endtask

   task automatic t_short_rx();
      int x0, i0, k;
      x0 = n_xfer; i0 = n_irq; k = 0;
      start(16'd64, 32'h3000, 1'b1, 1'b1, 1'b1);
      while (n_xfer - x0 < 4 && k < 500) begin @(negedge clk); k++; end
      ep_short_end = 1'b1;
      wait_done(500, "R4 short packet done");
      cycles(30);
      chk(n_xfer - x0 == 5, "R4 short word moved", n_xfer - x0, 5);
      chk(bytes_left == 16'd54, "R4 count after short", bytes_left, 54);
      chk(mem_addr == 32'h300A, "R4 addr after short", mem_addr, 32'h300A);
      chk(n_irq - i0 == 1, "R4 irq", n_irq - i0, 1);
      stop();
   endtask

   task automatic t_odd_coincide();
      int x0, i0, k;
      x0 = n_xfer; i0 = n_irq; k = 0;
      start(16'd5, 32'h4000, 1'b1, 1'b1, 1'b1);
      while (n_xfer - x0 < 2 && k < 500) begin @(negedge clk); k++; end
      ep_short_end = 1'b1;
      wait_done(500, "R10 done");
      cycles(20);
      chk(n_xfer - x0 == 3, "R9 odd last word moved", n_xfer - x0, 3);
      chk(bytes_left == 16'd0, "R9 clamp at zero", bytes_left, 0);
      chk(n_irq - i0 == 1, "R10 single irq", n_irq - i0, 1);
      stop();
   endtask

   task automatic t_tx_ignore_short();
      int x0;
      x0 = n_xfer;
      start(16'd8, 32'h5000, 1'b1, 1'b1, 1'b0);
      ep_short_end = 1'b1;
      wait_done(500, "R6 tx done");
      cycles(40);
      chk(n_xfer - x0 == 4, "R6 short ignored on tx", n_xfer - x0, 4);
      stop();
   endtask

   task automatic t_no_cnt_stop();
      int x0, i0;
      x0 = n_xfer; i0 = n_irq;
      start(16'd4, 32'h6000, 1'b0, 1'b0, 1'b1);
      cycles(60);
      chk(n_xfer - x0 > 4, "R11 continues past zero", n_xfer - x0, 5);
      chk(bytes_left == 16'd0, "R11 count stays zero", bytes_left, 0);
      chk(n_irq - i0 == 0 && xfer_done === 1'b0, "R11 no end", n_irq - i0, 0);
      stop();
   endtask

   task automatic t_disable();
      int x0, i0, k;
      x0 = n_xfer; i0 = n_irq; k = 0;
      start(16'd64, 32'h7000, 1'b1, 1'b0, 1'b0);
      while (n_xfer - x0 < 10 && k < 500) begin @(negedge clk); k++; end
      cycles(3);
      cfg_enable = 1'b0;
      #1;
      chk(bus_req === 1'b0, "R5 req drops at once", bus_req, 0);
      cycles(30);
      chk(n_xfer - x0 == 10, "R5 no more words", n_xfer - x0, 10);
      chk(n_irq - i0 == 0, "R5 no irq", n_irq - i0, 0);
      chk(xfer_done === 1'b0, "R5 done stays low", xfer_done, 0);
   endtask

   task automatic t_hold_grant();
      int x0;
      x0 = n_xfer;
      grant_hold = 4;
      start(16'd8, 32'h8000, 1'b1, 1'b0, 1'b0);
      wait_done(1000, "R7 done with slow grant release");
      chk(n_xfer - x0 == 4, "R7 words with held grant", n_xfer - x0, 4);
      chk(viol == 0, "R7 no request while granted", viol, 0);
      grant_hold = 0;
      stop();
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      cycles(3);
      t_reset();
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_full64();
      t_restart();
      t_short_rx();
      t_odd_coincide();
      t_tx_ignore_short();
      t_no_cnt_stop();
      t_disable();
      t_hold_grant();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule